// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a set of active-low request lines into the active-low binary index of the highest-numbered line that is asserted, the way interrupt request lines are ranked before they reach a processor. Each 8-line slice has an active-low enable input, an active-low group-select output that reports "some request won here", and an active-low enable output. The enable output goes low only when the slice is enabled and has nothing to report, so it can hand the decision down to a lower-ranked slice.

The top module chains a parameterised number of slices (two by default, giving a 16-to-4 encoder). The highest slice takes the external enable. Each lower slice takes its enable from the slice above it. The low code bits are the bitwise AND of all slice codes. The upper code bits name the winning slice, taken from the group-select lines. Two slice implementations can be chosen at elaboration: a priority scan, or a sum of "leading request" product terms. There is no clock and no state. Every output is a pure function of the inputs.

Top module: `prio_chain`

## Requirements
- R1: Among asserted requests (low), the one with the highest index wins; every lower-indexed request has no effect on the code while a higher one is asserted.
- R2: With the block enabled and request n winning, `code_n` equals the bitwise inverse of n. For example, request 5 alone gives 3'b010 on an 8-line build.
- R3: With `en_in_n` high, `code_n` is all ones, `grp_n` is high and `en_out_n` is high, whatever the requests are.
- R4: With `en_in_n` low and every request high, `code_n` is all ones, `grp_n` is high and `en_out_n` is low.
- R5: With `en_in_n` low and at least one request low, `grp_n` is low and `en_out_n` is high.
- R6: In the two-slice build, any asserted request among lines 8 to 15 outranks lines 0 to 7. The winner's index then appears inverted on `code_n`, with bit 3 low.
- R7: In the two-slice build, when lines 8 to 15 are all idle and the block is enabled, the low slice decides. `code_n[3]` is high and `code_n[2:0]` is the inverse of the low slice's winning index.
- R8: For every input combination free of unknowns, all outputs carry defined 0/1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | SLICE_W*SLICES | Active-low request lines; higher index has higher priority |
| en_in_n | input | 1 | Active-low enable for the whole chain |
| code_n | output | $clog2(SLICE_W)+$clog2(SLICES) | Active-low binary index of the winning request |
| grp_n | output | 1 | Active-low: some request won |
| en_out_n | output | 1 | Active-low: enabled with no request, lets a lower chain take over |

## Verification
The bench builds two instances. The first is the default two-slice, 16-line chain using the product-term slice. All 65,536 request patterns are applied to it under both enable levels, which covers every cross-slice priority case and every hand-off through the chained enable. The second is a single 8-line slice using the scan implementation, with no upper code bits. It is also swept exhaustively, so both generate variants and the degenerate merge with one slice are exercised.

// File: rtl/prio_pkg.sv
package prio_pkg;

   // implementation choices for one encoder slice
   localparam int unsigned STYLE_SCAN = 0;
   localparam int unsigned STYLE_SOP  = 1;

   // smallest index width that can name w items, never below 1
   function automatic int unsigned idx_bits(input int unsigned w);
      return (w <= 1) ? 1 : $clog2(w);
   endfunction

   // true when w is a power of two and at least 1
   function automatic bit is_pow2(input int unsigned w);
      return (w != 0) && ((w & (w - 1)) == 0);
   endfunction

endpackage

// File: rtl/prio_slice.sv
module prio_slice #(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned STYLE = prio_pkg::STYLE_SCAN
) (
   input  logic [IN_W-1:0]                     req_n,
   input  logic                                ei_n,
   output logic [prio_pkg::idx_bits(IN_W)-1:0] code_n,
   output logic                                gs_n,
   output logic                                eo_n
);
   localparam int unsigned IW = prio_pkg::idx_bits(IN_W);

   logic          any_req;
   logic          enabled;
   logic [IW-1:0] win_idx;

   assign enabled = ~ei_n;
   assign any_req = ~(&req_n);

   generate
      if (STYLE == prio_pkg::STYLE_SCAN) begin : g_scan
         // later (higher) lines overwrite earlier ones
         always_comb begin
            win_idx = '0;
            for (int i = 0; i < IN_W; i++) begin
               if (!req_n[i]) win_idx = IW'(i);
            end
         end
      end else begin : g_sop
         // lead[n]: line n asserted and every line above it idle
         logic [IN_W:0]   idle_above;
         logic [IN_W-1:0] lead;
         assign idle_above[IN_W] = 1'b1;
         for (genvar n = IN_W - 1; n >= 0; n--) begin : g_lead
            assign lead[n]          = ~req_n[n] & idle_above[n+1];
            assign idle_above[n]    = idle_above[n+1] & req_n[n];
         end
         for (genvar b = 0; b < IW; b++) begin : g_bit
            logic [IN_W-1:0] sel;
            for (genvar n = 0; n < IN_W; n++) begin : g_sel
               assign sel[n] = lead[n] & ((n >> b) & 1);
            end
            assign win_idx[b] = |sel;
         end
      end
   endgenerate

   assign code_n = (enabled && any_req) ? ~win_idx : '1;
   assign gs_n   = ~(enabled & any_req);
   assign eo_n   = ~(enabled & ~any_req);

endmodule

// File: rtl/prio_merge.sv
module prio_merge #(
   parameter int unsigned SLICES = 2,
   parameter int unsigned SW     = 3
) (
   input  logic [SLICES*SW-1:0]               slice_code_n,
   input  logic [SLICES-1:0]                  slice_gs_n,
   output logic [SW+$clog2(SLICES)-1:0]       code_n,
   output logic                               grp_n
);
   localparam int unsigned UW = $clog2(SLICES);

   // idle slices drive all ones, so AND keeps only the winner's code
   always_comb begin
      code_n[SW-1:0] = '1;
      for (int s = 0; s < SLICES; s++) begin
         code_n[SW-1:0] &= slice_code_n[s*SW +: SW];
      end
   end

   assign grp_n = &slice_gs_n;

   generate
      if (UW > 0) begin : g_upper
         // upper bit b low when the winning slice index has bit b set
         for (genvar b = 0; b < UW; b++) begin : g_ub
            logic [SLICES-1:0] pick;
            for (genvar s = 0; s < SLICES; s++) begin : g_pk
               assign pick[s] = ((s >> b) & 1) ? slice_gs_n[s] : 1'b1;
            end
            assign code_n[SW+b] = &pick;
         end
      end
   endgenerate

endmodule

// File: rtl/prio_chain.sv
module prio_chain #(
   parameter int unsigned SLICE_W = 8,
   parameter int unsigned SLICES  = 2,
   parameter int unsigned STYLE   = prio_pkg::STYLE_SOP
) (
   input  logic [SLICE_W*SLICES-1:0]                 req_n,
   input  logic                                      en_in_n,
   output logic [$clog2(SLICE_W)+$clog2(SLICES)-1:0] code_n,
   output logic                                      grp_n,
   output logic                                      en_out_n
);
   localparam int unsigned SW = prio_pkg::idx_bits(SLICE_W);

   generate
      if (!prio_pkg::is_pow2(SLICE_W) || SLICE_W < 2) begin : g_bad_w
         $error("prio_chain: SLICE_W must be a power of two >= 2");
      end
      if (!prio_pkg::is_pow2(SLICES)) begin : g_bad_s
         $error("prio_chain: SLICES must be a power of two");
      end
      if (STYLE > prio_pkg::STYLE_SOP) begin : g_bad_style
         $error("prio_chain: unknown STYLE");
      end
   endgenerate

   logic [SLICES:0]       en_chain_n;
   logic [SLICES*SW-1:0]  s_code_n;
   logic [SLICES-1:0]     s_gs_n;

   assign en_chain_n[SLICES] = en_in_n;

   generate
      for (genvar s = 0; s < SLICES; s++) begin : g_slice
         prio_slice #(
            .IN_W  (SLICE_W),
            .STYLE (STYLE)
         ) u_slice (
            .req_n  (req_n[s*SLICE_W +: SLICE_W]),
            .ei_n   (en_chain_n[s+1]),
            .code_n (s_code_n[s*SW +: SW]),
            .gs_n   (s_gs_n[s]),
            .eo_n   (en_chain_n[s])
         );
      end
   endgenerate

   prio_merge #(
      .SLICES (SLICES),
      .SW     (SW)
   ) u_merge (
      .slice_code_n (s_code_n),
      .slice_gs_n   (s_gs_n),
      .code_n       (code_n),
      .grp_n        (grp_n)
   );

   assign en_out_n = en_chain_n[0];

endmodule

// File: rtl/prio_chain_chk.sv
module prio_chain_chk #(
   parameter int unsigned SLICE_W = 8,
   parameter int unsigned SLICES  = 2
) (
   input logic [SLICE_W*SLICES-1:0]                 req_n,
   input logic                                      en_in_n,
   input logic [$clog2(SLICE_W)+$clog2(SLICES)-1:0] code_n,
   input logic                                      grp_n,
   input logic                                      en_out_n
);
   localparam int unsigned RW = SLICE_W * SLICES;
   localparam int unsigned CW = $clog2(SLICE_W) + $clog2(SLICES);

   logic [CW-1:0] win;
   logic [RW-1:0] above_idle_mask;
   logic          inputs_known;

   assign win          = ~code_n;
   assign inputs_known = !$isunknown({req_n, en_in_n});

   // lines strictly above the reported winner
   always_comb begin
      above_idle_mask = '0;
      for (int i = 0; i < RW; i++) begin
         if (i > int'(win)) above_idle_mask[i] = 1'b1;
      end
   end

   always_comb begin
      if (inputs_known) begin
         p_quiet_when_off_r3: assert (en_in_n == 1'b0 ||
            (code_n == '1 && grp_n && en_out_n))
            else $error("R3: disabled chain not quiet");
         p_handoff_when_idle_r4: assert (!(en_in_n == 1'b0 && &req_n) ||
            (code_n == '1 && grp_n && !en_out_n))
            else $error("R4: idle chain did not hand off");
         p_flags_on_grant_r5: assert (!(en_in_n == 1'b0 && !(&req_n)) ||
            (!grp_n && en_out_n))
            else $error("R5: grant flags wrong");
         p_winner_asserted_r1: assert (grp_n || req_n[win] == 1'b0)
            else $error("R1: reported line not asserted");
         p_nothing_above_r1: assert (grp_n || (req_n & above_idle_mask) == above_idle_mask)
            else $error("R1: higher line outranked");
         p_defined_outs_r8: assert (!$isunknown({code_n, grp_n, en_out_n}))
            else $error("R8: undefined output");
      end
   end

endmodule

bind prio_chain prio_chain_chk #(
   .SLICE_W (SLICE_W),
   .SLICES  (SLICES)
) u_chk (
   .req_n    (req_n),
   .en_in_n  (en_in_n),
   .code_n   (code_n),
   .grp_n    (grp_n),
   .en_out_n (en_out_n)
);

// File: tb/sim_prio_chain.sv
module sim_prio_chain;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 60000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // u0: two 8-line slices, product-term style
   logic [15:0] req0_n;
   logic        en0_n;
   logic [3:0]  code0_n;
   logic        grp0_n, eo0_n;

   prio_chain #(.SLICE_W(8), .SLICES(2), .STYLE(1)) u0 (
      .req_n(req0_n), .en_in_n(en0_n), .code_n(code0_n),
      .grp_n(grp0_n), .en_out_n(eo0_n));

   // u1: single 8-line slice, scan style
   logic [7:0] req1_n;
   logic       en1_n;
   logic [2:0] code1_n;
   logic       grp1_n, eo1_n;

   prio_chain #(.SLICE_W(8), .SLICES(1), .STYLE(0)) u1 (
      .req_n(req1_n), .en_in_n(en1_n), .code_n(code1_n),
      .grp_n(grp1_n), .en_out_n(eo1_n));

   // model from the requirements: {code_n[3:0], grp_n, en_out_n}
   function automatic logic [5:0] model(input logic [15:0] r, input logic en_n);
      int w = -1;
      for (int i = 0; i < 16; i++) if (!r[i]) w = i;
      if (en_n)        return 6'b1111_1_1;
      if (w < 0)       return 6'b1111_1_0;
      return {~4'(w), 1'b0, 1'b1};
   endfunction

   task automatic cmp16(input string tag);
      logic [5:0] exp, got;
      #1;
      exp = model(req0_n, en0_n);
      got = {code0_n, grp0_n, eo0_n};
      checks++;
      if (got !== exp || $isunknown(got)) begin
         errors++;
         $display("FAIL %s u0 req_n=%h en_n=%b got=%b exp=%b", tag, req0_n, en0_n, got, exp);
      end
   endtask

   task automatic cmp8(input string tag);
      logic [5:0] m;
      logic [4:0] exp, got;
      #1;
      m   = model({8'hFF, req1_n}, en1_n);
      exp = {m[4:2], m[1], m[0]};
      got = {code1_n, grp1_n, eo1_n};
      checks++;
      if (got !== exp || $isunknown(got)) begin
         errors++;
         $display("FAIL %s u1 req_n=%h en_n=%b got=%b exp=%b", tag, req1_n, en1_n, got, exp);
      end
   endtask

   task automatic t_idle_start;
      req0_n = '1; en0_n = 1'b0; cmp16("R4 idle start");
      req1_n = '1; en1_n = 1'b0; cmp8("R4 idle start");
   endtask

   task automatic t_disabled;
      en0_n = 1'b1;
      req0_n = 16'h0000; cmp16("R3 all asserted");
      req0_n = 16'h7FFF; cmp16("R3 top line");
      req0_n = 16'hFFFE; cmp16("R3 bottom line");
   endtask

   task automatic t_single_lines;
      en1_n = 1'b0;
      for (int n = 0; n < 8; n++) begin
         req1_n = ~(8'd1 << n); cmp8("R2 single line");
      end
      req1_n = 8'hDF; #1; checks++;
      if (code1_n !== 3'b010) begin
         errors++; $display("FAIL R2 line5 got=%b exp=010", code1_n);
      end
   endtask

   task automatic t_multi;
      en1_n = 1'b0;
      req1_n = 8'b1101_1011; cmp8("R1 lines 5 and 2");
      req1_n = 8'b0000_0000; cmp8("R1 all lines");
      req1_n = 8'b1111_1100; cmp8("R1 lines 1 and 0");
      req1_n = 8'b1111_1100; #1; checks++;
      if (grp1_n !== 1'b0 || eo1_n !== 1'b1) begin
         errors++; $display("FAIL R5 grp=%b eo=%b exp 0 1", grp1_n, eo1_n);
      end
   endtask

   task automatic t_cascade;
      en0_n = 1'b0;
      req0_n = ~(16'h1000 | 16'h0008); cmp16("R6 lines 12 and 3");
      req0_n = ~16'h0100;              cmp16("R6 line 8");
      req0_n = ~16'h0040;              cmp16("R7 line 6 only");
      req0_n = ~16'h00FF;              cmp16("R7 low half full");
   endtask

   task automatic t_sweep16;
      for (int e = 0; e < 2; e++) begin
         for (int v = 0; v < 65536; v++) begin
            en0_n  = e[0];
            req0_n = v[15:0];
            if (e != 0)           cmp16("R3 sweep");
            else if (v == 65535)  cmp16("R4 sweep");
            else if (v[15:8] != 8'hFF) cmp16("R6 sweep");
            else                  cmp16("R7 sweep");
         end
      end
   endtask

   task automatic t_sweep8;
      for (int e = 0; e < 2; e++) begin
         for (int v = 0; v < 256; v++) begin
            en1_n = e[0]; req1_n = v[7:0]; cmp8("R8 sweep");
         end
      end
   endtask

   initial begin
      req0_n = '1; en0_n = 1'b1; req1_n = '1; en1_n = 1'b1;
      @(negedge clk);
      t_idle_start();
      t_disabled();
      t_single_lines();
      t_multi();
      t_cascade();
      t_sweep8();
      t_sweep16();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule